// File: doc/BRIEF.md
# Bridge DMA Chunk Sequencer

This block paces a DMA transfer between an internal system bus and an external bus that share one DWORD FIFO. The transfer is cut into chunks. A 2-bit mode input picks the chunk size: one DWORD per chunk, or bursts of sixteen DWORDs. Before each chunk the sequencer waits for the FIFO level to cover the whole chunk. When the direction is internal-to-external it waits for free space. When the direction is external-to-internal it waits for stored data.

Each chunk has two phases. First comes a source phase of read beats, then a destination phase of write beats, and the two phases never overlap. Each beat is a simple request/acknowledge handshake. After the last write beat of a chunk, the remaining-DWORD count drops by the size of that chunk. In burst mode, a total that is not a multiple of sixteen ends with a shorter chunk that carries only the remainder.

When the count reaches zero the block raises a one-cycle done pulse. In that same cycle it looks at a chain-hold input. If the input is low, it loads the next-descriptor address into its chain address register.

Top module: `dma_chunk_seq`

## Requirements
- R1: With mode 00 every chunk moves exactly 1 DWORD: one source beat followed by one destination beat.
- R2: With mode 01 every chunk except possibly the final one moves 16 DWORDs, as 16 source beats followed by 16 destination beats.
- R3: Mode values 10 and 11 behave exactly like mode 00 (single-DWORD chunks).
- R4: Within a chunk all source beats complete before the first destination request, and `src_req` and `dst_req` are never high together.
- R5: With `dir`=0, a chunk's source phase starts only when `fifo_free` is at least the chunk size; otherwise `src_req` stays low.
- R6: With `dir`=1, a chunk's source phase starts only when `fifo_used` is at least the chunk size; otherwise `src_req` stays low.
- R7: In mode 01, when the total is not a multiple of 16, the final chunk moves only the remaining (count mod 16) DWORDs.
- R8: `remaining` loads the requested count on start and, in the cycle after a chunk's last destination acknowledge, drops by that chunk's size.
- R9: When `remaining` reaches zero (or a transfer starts with count 0, moving no beats) `done` is high for exactly one cycle and `busy` then returns low.
- R10: In the done cycle, if `chain_hold` is 0, `chain_load` is high and `chain_addr` takes `next_desc` on the next edge; if `chain_hold` is 1, `chain_load` stays low and `chain_addr` keeps its value.
- R11: `last_beat` is high exactly while a request is outstanding for the final beat of the current phase.
- R12: After reset no request is raised, `busy` and `done` are low, and `remaining` and `chain_addr` are zero.
- R13: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (sampled when idle) |
| mode | input | 2 | Chunk mode: 00 single, 01 burst of 16, 10/11 single |
| dir | input | 1 | 0: internal to external (gate on free space), 1: external to internal (gate on occupancy) |
| xfer_count | input | CNT_W | Total DWORDs to move |
| fifo_free | input | LVL_W | Free DWORD slots in the FIFO |
| fifo_used | input | LVL_W | DWORDs held in the FIFO |
| src_req | output | 1 | Source read beat request |
| src_ack | input | 1 | Source beat completes |
| dst_req | output | 1 | Destination write beat request |
| dst_ack | input | 1 | Destination beat completes |
| last_beat | output | 1 | Current request is the final beat of its phase |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| remaining | output | CNT_W | DWORDs still to move |
| chain_hold | input | 1 | 0: load next descriptor address at end |
| next_desc | input | ADDR_W | Next-descriptor address from the current descriptor |
| chain_load | output | 1 | Chain address is being loaded this cycle |
| chain_addr | output | ADDR_W | Chain address register |

## Verification
The bench holds the FIFO level one DWORD short of a full chunk in each direction. A design that compared against the wrong level, or that gated a shortened final chunk on a full sixteen, would either start too early or hang. Totals of 21 and 32 DWORDs in burst mode test the remainder and the exact-multiple cases: an off-by-one chunk length shows up as a wrong beat count or a wrong `remaining` value. A zero count, the reserved modes, a start pulse in the middle of a transfer and both values of the chain-hold input complete the set. A design that mishandled any of these would report done at the wrong time, move extra beats, restart with a new count or overwrite the chain address.

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq #(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 6,
  parameter int BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              dir,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic [LVL_W-1:0]  fifo_free,
  input  logic [LVL_W-1:0]  fifo_used,
  output logic              src_req,
  input  logic              src_ack,
  output logic              dst_req,
  input  logic              dst_ack,
  output logic              last_beat,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  remaining,
  input  logic              chain_hold,
  input  logic [ADDR_W-1:0] next_desc,
  output logic              chain_load,
  output logic [ADDR_W-1:0] chain_addr
);

  localparam int LEN_W = $clog2(BURST_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_GATE, S_SRC, S_DST, S_END} st_t;

  st_t              st;
  logic             burst_q, dir_q;
  logic [LEN_W-1:0] len_q, beat_q, need;
  logic [CNT_W-1:0] rem_q;
  logic             level_ok, beat_end;

  assign need     = !burst_q ? LEN_W'(1) :
                    (32'(rem_q) < BURST_LEN) ? LEN_W'(rem_q) : LEN_W'(BURST_LEN);
  assign level_ok = dir_q ? (32'(fifo_used) >= 32'(need)) : (32'(fifo_free) >= 32'(need));
  assign beat_end = beat_q == len_q - LEN_W'(1);

  assign src_req    = st == S_SRC;
  assign dst_req    = st == S_DST;
  assign last_beat  = (src_req || dst_req) && beat_end;
  assign busy       = st != S_IDLE;
  assign done       = st == S_END;
  assign remaining  = rem_q;
  assign chain_load = done && !chain_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      burst_q    <= 1'b0;
      dir_q      <= 1'b0;
      len_q      <= '0;
      beat_q     <= '0;
      rem_q      <= '0;
      chain_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rem_q   <= xfer_count;
          burst_q <= mode == 2'b01;
          dir_q   <= dir;
          st      <= (xfer_count == '0) ? S_END : S_GATE;
        end
        S_GATE: if (level_ok) begin
          len_q  <= need;
          beat_q <= '0;
          st     <= S_SRC;
        end
        S_SRC: if (src_ack) begin
          if (beat_end) begin
            beat_q <= '0;
            st     <= S_DST;
          end else begin
            beat_q <= beat_q + LEN_W'(1);
          end
        end
        S_DST: if (dst_ack) begin
          if (beat_end) begin
            rem_q <= rem_q - CNT_W'(len_q);
            st    <= (rem_q == CNT_W'(len_q)) ? S_END : S_GATE;
          end else begin
            beat_q <= beat_q + LEN_W'(1);
          end
        end
        S_END: begin
          if (!chain_hold) chain_addr <= next_desc;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chunk_seq_chk.sv
module dma_chunk_seq_chk #(
  parameter int CNT_W     = 16,
  parameter int LVL_W     = 6,
  parameter int LEN_W     = 5,
  parameter int BURST_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_req,
  input logic             src_ack,
  input logic             dst_req,
  input logic             dst_ack,
  input logic             last_beat,
  input logic             busy,
  input logic             done,
  input logic             chain_load,
  input logic [CNT_W-1:0] remaining,
  input logic [LVL_W-1:0] fifo_free,
  input logic [LVL_W-1:0] fifo_used,
  input logic             dir_q,
  input logic             burst_q,
  input logic [LEN_W-1:0] len_q
);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_req && dst_req));

  assert_src_before_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_req) |-> $past(src_req && src_ack && last_beat));

  assert_free_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(src_req) && !dir_q) |-> $past(32'(fifo_free)) >= 32'(len_q));

  assert_used_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(src_req) && dir_q) |-> $past(32'(fifo_used)) >= 32'(len_q));

  assert_chunk_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_req |-> (len_q != '0) && (32'(len_q) <= BURST_LEN));

  assert_single_chunk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !burst_q) |-> len_q == LEN_W'(1));

  assert_count_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && dst_ack && last_beat) |=> remaining == $past(remaining) - CNT_W'($past(len_q)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_chain_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chain_load |-> done);

  assert_last_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (src_req || dst_req));

endmodule

bind dma_chunk_seq dma_chunk_seq_chk #(
  .CNT_W(CNT_W), .LVL_W(LVL_W), .LEN_W(LEN_W), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_ack(src_ack),
  .dst_req(dst_req), .dst_ack(dst_ack), .last_beat(last_beat), .busy(busy),
  .done(done), .chain_load(chain_load), .remaining(remaining),
  .fifo_free(fifo_free), .fifo_used(fifo_used), .dir_q(dir_q),
  .burst_q(burst_q), .len_q(len_q)
);

// File: tb/sim_dma_chunk_seq.sv
module sim_dma_chunk_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        dir = 1'b0;
  logic [15:0] xfer_count = '0;
  logic [5:0]  fifo_free = 6'd32;
  logic [5:0]  fifo_used = 6'd32;
  logic        src_ack = 1'b0;
  logic        dst_ack = 1'b0;
  logic        chain_hold = 1'b0;
  logic [31:0] next_desc = '0;
  logic        src_req, dst_req, last_beat, busy, done, chain_load;
  logic [15:0] remaining;
  logic [31:0] chain_addr;

  always #2 clk = ~clk;

  dma_chunk_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
    .xfer_count(xfer_count), .fifo_free(fifo_free), .fifo_used(fifo_used),
    .src_req(src_req), .src_ack(src_ack), .dst_req(dst_req), .dst_ack(dst_ack),
    .last_beat(last_beat), .busy(busy), .done(done), .remaining(remaining),
    .chain_hold(chain_hold), .next_desc(next_desc), .chain_load(chain_load),
    .chain_addr(chain_addr)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_tag = "R12";

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 wait level, 2 source, 3 destination, 4 end
  int m_st, m_rem, m_len, m_beat, m_burst, m_dir;
  longint m_caddr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_len = 0; m_beat = 0; m_burst = 0; m_dir = 0; m_caddr = 0;
    end else begin
      case (m_st)
        0: if (start) begin
          m_rem = xfer_count; m_burst = (mode == 2'b01); m_dir = dir;
          m_st = (xfer_count == 0) ? 4 : 1;
        end
        1: begin
          int need, lvl;
          need = m_burst ? ((m_rem < 16) ? m_rem : 16) : 1;
          lvl  = m_dir ? fifo_used : fifo_free;
          if (lvl >= need) begin m_len = need; m_beat = 0; m_st = 2; end
        end
        2: if (src_ack) begin
          if (m_beat == m_len - 1) begin m_beat = 0; m_st = 3; end
          else m_beat++;
        end
        3: if (dst_ack) begin
          if (m_beat == m_len - 1) begin m_rem -= m_len; m_st = (m_rem == 0) ? 4 : 1; end
          else m_beat++;
        end
        default: begin
          if (!chain_hold) m_caddr = next_desc;
          m_st = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_tag, "src_req", src_req, m_st == 2);
      check(cur_tag, "dst_req", dst_req, m_st == 3);
      check("R11", "last_beat", last_beat, (m_st == 2 || m_st == 3) && m_beat == m_len - 1);
      check("R8", "remaining", remaining, m_rem);
      check("R9", "done", done, m_st == 4);
      check("R9", "busy", busy, m_st != 0);
      check("R10", "chain_load", chain_load, m_st == 4 && !chain_hold);
      check("R10", "chain_addr", chain_addr, m_caddr);
    end
  end

  int total_rd, rd_run, max_run, last_run;
  always @(posedge clk) begin
    if (src_req && src_ack) begin total_rd++; rd_run++; end
    if (dst_req && dst_ack && last_beat) begin
      if (rd_run > max_run) max_run = rd_run;
      last_run = rd_run; rd_run = 0;
    end
  end

  int ack_cnt = 0;
  initial forever begin
    @(posedge clk); #1;
    ack_cnt++;
    src_ack = (ack_cnt % 4) != 2;
    dst_ack = (ack_cnt % 5) != 3;
  end

  task automatic kick(input string tag, input logic [1:0] md, input logic d, input int cnt,
                      input logic hold, input logic [31:0] nd);
    @(posedge clk); #1;
    cur_tag = tag; mode = md; dir = d; xfer_count = 16'(cnt); chain_hold = hold; next_desc = nd;
    total_rd = 0; rd_run = 0; max_run = 0; last_run = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_xfer(input string tag, input int cnt, input int exp_max, input int exp_last);
    while (!done) @(negedge clk);
    @(posedge clk); #1;
    check(tag, "beats moved", total_rd, cnt);
    check(tag, "largest chunk", max_run, exp_max);
    check(tag, "final chunk", last_run, exp_last);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R12", "src_req", src_req, 0);
    check("R12", "busy", busy, 0);
    check("R12", "done", done, 0);
    check("R12", "remaining", remaining, 0);
    check("R12", "chain_addr", chain_addr, 0);

    kick("R1", 2'b00, 1'b0, 3, 1'b0, 32'h1000);
    finish_xfer("R1", 3, 1, 1);
    check("R10", "chain loaded", chain_addr, 32'h1000);

    kick("R2", 2'b01, 1'b0, 32, 1'b0, 32'h2000);
    finish_xfer("R2", 32, 16, 16);

    kick("R7", 2'b01, 1'b1, 21, 1'b0, 32'h3000);
    finish_xfer("R7", 21, 16, 5);

    kick("R3", 2'b10, 1'b0, 2, 1'b0, 32'h4000);
    finish_xfer("R3", 2, 1, 1);
    kick("R3", 2'b11, 1'b1, 2, 1'b0, 32'h4100);
    finish_xfer("R3", 2, 1, 1);

    fifo_free = 6'd15;
    kick("R5", 2'b01, 1'b0, 16, 1'b0, 32'h5000);
    repeat (20) @(negedge clk);
    check("R5", "src_req held off", src_req, 0);
    @(posedge clk); #1 fifo_free = 6'd16;
    finish_xfer("R5", 16, 16, 16);
    fifo_free = 6'd0;
    kick("R5", 2'b00, 1'b0, 1, 1'b0, 32'h5100);
    repeat (6) @(negedge clk);
    check("R5", "src_req held off", src_req, 0);
    @(posedge clk); #1 fifo_free = 6'd1;
    finish_xfer("R5", 1, 1, 1);
    fifo_free = 6'd32;

    fifo_used = 6'd15;
    kick("R6", 2'b01, 1'b1, 20, 1'b0, 32'h6000);
    repeat (20) @(negedge clk);
    check("R6", "src_req held off", src_req, 0);
    @(posedge clk); #1 fifo_used = 6'd16;
    while (!(dst_req && last_beat)) @(negedge clk);
    @(posedge clk); #1 fifo_used = 6'd3;
    repeat (10) @(negedge clk);
    check("R6", "short chunk held off", src_req, 0);
    @(posedge clk); #1 fifo_used = 6'd4;
    finish_xfer("R6", 20, 16, 4);
    fifo_used = 6'd32;

    kick("R9", 2'b01, 1'b0, 0, 1'b0, 32'h7000);
    finish_xfer("R9", 0, 0, 0);
    check("R10", "chain loaded on empty", chain_addr, 32'h7000);

    kick("R10", 2'b00, 1'b0, 2, 1'b1, 32'hABCD);
    finish_xfer("R10", 2, 1, 1);
    check("R10", "chain kept", chain_addr, 32'h7000);

    kick("R13", 2'b00, 1'b0, 4, 1'b0, 32'h8000);
    repeat (3) @(posedge clk);
    #1 xfer_count = 16'd50; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    finish_xfer("R13", 4, 1, 1);
    repeat (3) @(negedge clk);
    check("R13", "idle after", busy, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule